// File: doc/BRIEF.md
# Bridge Window Address Translator

This block rewrites the addresses of memory transactions that pass between two isolated processor domains joined by a bridge. Each side of the bridge (side 0 and side 1) owns its own independent set of address windows. A window holds a base address, a setup word that gives its enable, its size and its translation type, and a translation word. An incoming request names the side it arrived on. Its address is compared against that side's enabled windows. The lowest-numbered matching window then produces the outgoing address.

Two translation types exist. In direct mode, the offset inside the window is added to the translation word. In lookup mode, a 5-bit index field is cut from the incoming address at a programmable bit position. That index selects one entry of a per-side table, and the entry supplies the address bits above that position. Configuration requests are a separate kind of request: they are accepted only when their bus number equals the bridge's own bus number. Software programs every window, table entry and the own bus number through a single write-only register port.

Top module: `bwat_top`

## Requirements
- R1: A request presented with `req_valid` high on a clock edge yields `rsp_valid` high, with its outcome, after exactly that edge. In a cycle with no request, `rsp_valid`, `rsp_hit`, `rsp_miss` and `rsp_cfg_ok` are all low.
- R2: A window matches when its enable is set and the request address agrees with the window base in every bit at or above the window size. The size is 2^S bytes, where S is the setup field, and any S below 12 counts as 12. The match uses only the windows of the side given by `req_side`.
- R3: In direct mode, the outgoing address is the translation word plus the offset of the address inside the window.
- R4: In lookup mode, the index is the 5 address bits starting at bit P, where P is the setup position field (P from 12 to 26). The outgoing address takes the table entry's bits at and above P, and the request address's bits below P.
- R5: A lookup-mode match whose selected table entry has bit 0 (valid) clear gives a miss.
- R6: A memory request that matches no enabled window, or that hits an invalid table entry, gives `rsp_miss` high and `rsp_addr` zero.
- R7: When several windows match, the lowest-numbered one is used, and its number appears on `rsp_win`.
- R8: A request with `req_cfg` high gives `rsp_cfg_ok` when `req_bus` equals the programmed own bus number, and a miss otherwise. It never gives `rsp_hit`.
- R9: A register write with `reg_we` high takes effect for requests sampled from the next clock edge on. The write target is chosen by address bits, as follows.
  - `reg_addr[7:6]=00` selects a window register. Bit 5 is the side and bits 2:0 are the window number. Bits 4:3 pick the register: 0 is the base, 1 is the setup word, 2 is the translation word.
  - The setup word holds enable in bit 0, mode in bit 1 (1 = lookup), S in bits 6:2 and P in bits 11:7.
  - `reg_addr[7:6]=01` selects a table entry. Bit 5 is the side and bits 4:0 are the index.
  - `reg_addr[7:6]=10` sets the own bus number from `reg_wdata[7:0]`.
- R10: After reset, all windows are disabled, every table entry is invalid, and all response outputs are zero.
- R11: Whenever `rsp_valid` is high, exactly one of `rsp_hit`, `rsp_miss` and `rsp_cfg_ok` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present this cycle |
| req_side | input | 1 | Side the request arrived on |
| req_cfg | input | 1 | Request is a configuration access |
| req_bus | input | 8 | Bus number of a configuration access |
| req_addr | input | 32 | Request address |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register write target |
| reg_wdata | input | 32 | Register write data |
| rsp_valid | output | 1 | Response present |
| rsp_hit | output | 1 | Memory request translated |
| rsp_miss | output | 1 | Request rejected |
| rsp_cfg_ok | output | 1 | Configuration access accepted |
| rsp_win | output | 2 | Number of the window that produced the hit |
| rsp_addr | output | 32 | Translated address, zero unless hit |

## Verification
The assertions assume that `req_valid` stays low while reset is held. They also assume that the register port is never written in the same cycle as a request whose outcome is being checked, because a concurrent write would let a response mix old and new settings. The stimulus drives only between edges, raises `req_valid` only after reset is released, and finishes all programming before each group of requests. Lookup positions are kept between 12 and 26 so that the index field always lies inside the address.

// File: rtl/bwat_pkg.sv
package bwat_pkg;
  localparam int ADDR_W   = 32;
  localparam int MIN_SIZE = 12;

  typedef struct packed {
    logic [4:0] idx_pos;
    logic [4:0] size_log2;
    logic       lut_mode;
    logic       en;
  } win_setup_t;

  function automatic win_setup_t decode_setup(input logic [ADDR_W-1:0] w);
    win_setup_t s;
    s.en        = w[0];
    s.lut_mode  = w[1];
    s.size_log2 = w[6:2];
    s.idx_pos   = w[11:7];
    return s;
  endfunction

  // Low-bit mask covering the offset inside a window of 2^s bytes.
  function automatic logic [ADDR_W-1:0] size_mask(input logic [4:0] s);
    logic [4:0] eff;
    eff = (s < 5'(MIN_SIZE)) ? 5'(MIN_SIZE) : s;
    return (ADDR_W'(1) << eff) - ADDR_W'(1);
  endfunction

  function automatic logic [ADDR_W-1:0] direct_xlat(input logic [ADDR_W-1:0] a,
                                                    input logic [ADDR_W-1:0] xl,
                                                    input logic [ADDR_W-1:0] m);
    return xl + (a & m);
  endfunction

  function automatic logic [ADDR_W-1:0] lut_xlat(input logic [ADDR_W-1:0] a,
                                                 input logic [ADDR_W-1:0] entry,
                                                 input logic [4:0] pos);
    logic [ADDR_W-1:0] m;
    m = (ADDR_W'(1) << pos) - ADDR_W'(1);
    return (entry & ~m) | (a & m);
  endfunction
endpackage

// File: rtl/bwat_regs.sv
module bwat_regs
  import bwat_pkg::*;
#(
  parameter int NWIN      = 4,
  parameter int LUT_DEPTH = 32,
  localparam int LIW      = $clog2(LUT_DEPTH)
) (
  input  logic                                   clk,
  input  logic                                   rst_n,
  input  logic                                   we,
  input  logic [7:0]                             waddr,
  input  logic [ADDR_W-1:0]                      wdata,
  output logic [1:0][NWIN-1:0][ADDR_W-1:0]       base_q,
  output logic [1:0][NWIN-1:0][ADDR_W-1:0]       setup_q,
  output logic [1:0][NWIN-1:0][ADDR_W-1:0]       xlat_q,
  output logic [1:0][LUT_DEPTH-1:0][ADDR_W-1:0]  lut_q,
  output logic [7:0]                             self_bus_q
);
  logic win_sel, lut_sel, bus_sel;
  assign win_sel = we && (waddr[7:6] == 2'b00);
  assign lut_sel = we && (waddr[7:6] == 2'b01);
  assign bus_sel = we && (waddr[7:6] == 2'b10);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      base_q     <= '0;
      setup_q    <= '0;
      xlat_q     <= '0;
      lut_q      <= '0;
      self_bus_q <= '0;
    end else begin
      for (int s = 0; s < 2; s++) begin
        for (int w = 0; w < NWIN; w++) begin
          if (win_sel && waddr[5] == 1'(s) && waddr[2:0] == 3'(w)) begin
            case (waddr[4:3])
              2'd0:    base_q[s][w]  <= wdata;
              2'd1:    setup_q[s][w] <= wdata;
              2'd2:    xlat_q[s][w]  <= wdata;
              default: ;
            endcase
          end
        end
        for (int e = 0; e < LUT_DEPTH; e++) begin
          if (lut_sel && waddr[5] == 1'(s) && waddr[4:0] == 5'(e))
            lut_q[s][e] <= wdata;
        end
      end
      if (bus_sel) self_bus_q <= wdata[7:0];
    end
  end
endmodule

// File: rtl/bwat_match.sv
module bwat_match
  import bwat_pkg::*;
#(
  parameter int NWIN    = 4,
  localparam int WIN_W  = (NWIN > 1) ? $clog2(NWIN) : 1
) (
  input  logic [ADDR_W-1:0]            addr,
  input  logic [NWIN-1:0][ADDR_W-1:0]  base,
  input  logic [NWIN-1:0][ADDR_W-1:0]  setup,
  output logic [NWIN-1:0]              hit_vec,
  output logic [NWIN-1:0]              grant_vec,
  output logic [WIN_W-1:0]             win_idx
);
  for (genvar w = 0; w < NWIN; w++) begin : g_win
    win_setup_t        su;
    logic [ADDR_W-1:0] m;
    assign su         = decode_setup(setup[w]);
    assign m          = size_mask(su.size_log2);
    assign hit_vec[w] = su.en && ((addr & ~m) == (base[w] & ~m));
  end

  // Lowest-numbered hit wins: scan downward so the last write is the lowest.
  always_comb begin
    grant_vec = '0;
    win_idx   = '0;
    for (int w = NWIN - 1; w >= 0; w--) begin
      if (hit_vec[w]) begin
        grant_vec    = '0;
        grant_vec[w] = 1'b1;
        win_idx      = WIN_W'(w);
      end
    end
  end
endmodule

// File: rtl/bwat_top.sv
module bwat_top
  import bwat_pkg::*;
#(
  parameter int NWIN      = 4,
  parameter int LUT_DEPTH = 32,
  localparam int WIN_W    = (NWIN > 1) ? $clog2(NWIN) : 1,
  localparam int LIW      = $clog2(LUT_DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_side,
  input  logic              req_cfg,
  input  logic [7:0]        req_bus,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic              reg_we,
  input  logic [7:0]        reg_addr,
  input  logic [ADDR_W-1:0] reg_wdata,
  output logic              rsp_valid,
  output logic              rsp_hit,
  output logic              rsp_miss,
  output logic              rsp_cfg_ok,
  output logic [WIN_W-1:0]  rsp_win,
  output logic [ADDR_W-1:0] rsp_addr
);
  logic [1:0][NWIN-1:0][ADDR_W-1:0]      base_q, setup_q, xlat_q;
  logic [1:0][LUT_DEPTH-1:0][ADDR_W-1:0] lut_q;
  logic [7:0]                            self_bus_q;

  bwat_regs #(.NWIN(NWIN), .LUT_DEPTH(LUT_DEPTH)) u_regs (
    .clk(clk), .rst_n(rst_n), .we(reg_we), .waddr(reg_addr), .wdata(reg_wdata),
    .base_q(base_q), .setup_q(setup_q), .xlat_q(xlat_q), .lut_q(lut_q),
    .self_bus_q(self_bus_q)
  );

  // Named internal events, brought out for the checker.
  logic [NWIN-1:0]  win_hit, win_grant;
  logic [WIN_W-1:0] win_idx;
  logic             any_hit, lut_entry_ok, cfg_match;

  bwat_match #(.NWIN(NWIN)) u_match (
    .addr(req_addr), .base(base_q[req_side]), .setup(setup_q[req_side]),
    .hit_vec(win_hit), .grant_vec(win_grant), .win_idx(win_idx)
  );

  win_setup_t        gsu;
  logic [ADDR_W-1:0] gmask, lut_entry;
  logic [LIW-1:0]    lut_idx;

  assign any_hit      = |win_hit;
  assign gsu          = decode_setup(setup_q[req_side][win_idx]);
  assign gmask        = size_mask(gsu.size_log2);
  assign lut_idx      = LIW'(req_addr >> gsu.idx_pos);
  assign lut_entry    = lut_q[req_side][lut_idx];
  assign lut_entry_ok = lut_entry[0];
  assign cfg_match    = (req_bus == self_bus_q);

  logic              nxt_hit, nxt_miss, nxt_cfg;
  logic [ADDR_W-1:0] nxt_addr;

  always_comb begin
    nxt_hit  = 1'b0;
    nxt_miss = 1'b0;
    nxt_cfg  = 1'b0;
    nxt_addr = '0;
    if (req_cfg) begin
      nxt_cfg  = cfg_match;
      nxt_miss = !cfg_match;
    end else if (!any_hit) begin
      nxt_miss = 1'b1;
    end else if (gsu.lut_mode) begin
      if (lut_entry_ok) begin
        nxt_hit  = 1'b1;
        nxt_addr = lut_xlat(req_addr, lut_entry, gsu.idx_pos);
      end else begin
        nxt_miss = 1'b1;
      end
    end else begin
      nxt_hit  = 1'b1;
      nxt_addr = direct_xlat(req_addr, xlat_q[req_side][win_idx], gmask);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid  <= 1'b0;
      rsp_hit    <= 1'b0;
      rsp_miss   <= 1'b0;
      rsp_cfg_ok <= 1'b0;
      rsp_win    <= '0;
      rsp_addr   <= '0;
    end else begin
      rsp_valid  <= req_valid;
      rsp_hit    <= req_valid && nxt_hit;
      rsp_miss   <= req_valid && nxt_miss;
      rsp_cfg_ok <= req_valid && nxt_cfg;
      rsp_win    <= (req_valid && nxt_hit) ? win_idx : '0;
      rsp_addr   <= req_valid ? nxt_addr : '0;
    end
  end
endmodule

// File: rtl/bwat_chk.sv
module bwat_chk #(
  parameter int NWIN  = 4,
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_cfg,
  input logic              rsp_valid,
  input logic              rsp_hit,
  input logic              rsp_miss,
  input logic              rsp_cfg_ok,
  input logic [ADDR_W-1:0] rsp_addr,
  input logic [NWIN-1:0]   win_hit,
  input logic [NWIN-1:0]   win_grant
);
  AST_RSP_AFTER_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> rsp_valid); // R1
  AST_NO_RSP_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !rsp_valid); // R1
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !rsp_valid |-> !(rsp_hit || rsp_miss || rsp_cfg_ok)); // R1
  AST_ONE_OUTCOME: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> ($countones({rsp_hit, rsp_miss, rsp_cfg_ok}) == 1)); // R11
  AST_MISS_ADDR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_miss |-> (rsp_addr == '0)); // R6
  AST_GRANT_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(win_grant)); // R7
  AST_GRANT_LOWEST: assert property (@(posedge clk) disable iff (!rst_n)
    ((win_grant - 1'b1) & win_hit) == '0); // R7
  AST_CFG_NEVER_HIT: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_cfg) |=> !rsp_hit); // R8
endmodule

bind bwat_top bwat_chk #(.NWIN(NWIN), .ADDR_W(bwat_pkg::ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_cfg(req_cfg),
  .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_miss(rsp_miss),
  .rsp_cfg_ok(rsp_cfg_ok), .rsp_addr(rsp_addr),
  .win_hit(win_hit), .win_grant(win_grant)
);

// File: tb/sim_bwat_top.sv
module sim_bwat_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, req_side = 1'b0, req_cfg = 1'b0;
  logic [7:0]  req_bus = '0;
  logic [31:0] req_addr = '0;
  logic        reg_we = 1'b0;
  logic [7:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic        rsp_valid, rsp_hit, rsp_miss, rsp_cfg_ok;
  logic [1:0]  rsp_win;
  logic [31:0] rsp_addr;
  int          errors = 0, checks = 0;

  always #5 clk = ~clk;

  bwat_top u0 (.*);

  localparam logic [1:0] K_HIT = 2'd0, K_MISS = 2'd1, K_CFG = 2'd2;

  typedef struct packed {
    logic        side;
    logic        cfg;
    logic [7:0]  bus;
    logic [31:0] addr;
    logic [1:0]  kind;
    logic [1:0]  win;
    logic [31:0] xaddr;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 13;
  localparam vec_t VEC [NV] = '{
    '{1'b0, 1'b0, 8'd0, 32'h1000_1234, K_HIT,  2'd0, 32'h8000_1234, 4'd7}, // R7 overlap
    '{1'b0, 1'b0, 8'd0, 32'h1008_0010, K_HIT,  2'd1, 32'h4008_0010, 4'd3}, // R3 direct
    '{1'b0, 1'b0, 8'd0, 32'h100F_FFFF, K_HIT,  2'd1, 32'h400F_FFFF, 4'd2}, // R2 top edge
    '{1'b0, 1'b0, 8'd0, 32'h1010_0000, K_MISS, 2'd0, 32'h0,         4'd2}, // R2 past edge
    '{1'b0, 1'b0, 8'd0, 32'h2003_5678, K_HIT,  2'd2, 32'hABCD_5678, 4'd4}, // R4 lookup
    '{1'b0, 1'b0, 8'd0, 32'h2004_0000, K_MISS, 2'd0, 32'h0,         4'd5}, // R5 invalid entry
    '{1'b0, 1'b0, 8'd0, 32'h3000_0004, K_MISS, 2'd0, 32'h0,         4'd6}, // R6 disabled
    '{1'b1, 1'b0, 8'd0, 32'h1000_0FFF, K_HIT,  2'd0, 32'h0005_0FFF, 4'd2}, // R2 side 1
    '{1'b1, 1'b0, 8'd0, 32'h1000_1000, K_MISS, 2'd0, 32'h0,         4'd6}, // R6 side 1
    '{1'b1, 1'b0, 8'd0, 32'h4033_0ABC, K_HIT,  2'd1, 32'h1233_0ABC, 4'd4}, // R4 side 1
    '{1'b0, 1'b0, 8'd0, 32'h4033_0ABC, K_MISS, 2'd0, 32'h0,         4'd2}, // R2 sides apart
    '{1'b0, 1'b1, 8'd5, 32'h0,         K_CFG,  2'd0, 32'h0,         4'd8}, // R8 own bus
    '{1'b0, 1'b1, 8'd6, 32'h0,         K_MISS, 2'd0, 32'h0,         4'd8}  // R8 other bus
  };

  function automatic logic [31:0] setup_w(input logic en, input logic lut,
                                          input int sz, input int pos);
    return {20'd0, 5'(pos), 5'(sz), lut, en};
  endfunction

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic wr_win(input logic side, input int w, input logic [31:0] base,
                        input logic [31:0] su, input logic [31:0] xl);
    wr({2'b00, side, 2'd0, 3'(w)}, base);
    wr({2'b00, side, 2'd1, 3'(w)}, su);
    wr({2'b00, side, 2'd2, 3'(w)}, xl);
  endtask

  task automatic check(input string tag, input logic [1:0] kind,
                       input logic [1:0] win, input logic [31:0] xaddr);
    logic ok;
    checks++;
    ok = rsp_valid && rsp_hit == (kind == K_HIT) && rsp_miss == (kind == K_MISS) &&
         rsp_cfg_ok == (kind == K_CFG) && rsp_addr == xaddr &&
         (kind != K_HIT || rsp_win == win);
    if (!ok) begin
      errors++;
      $display("FAIL %s: got v=%0b h=%0b m=%0b c=%0b win=%0d addr=%h, exp kind=%0d win=%0d addr=%h",
               tag, rsp_valid, rsp_hit, rsp_miss, rsp_cfg_ok, rsp_win, rsp_addr,
               kind, win, xaddr);
    end
  endtask

  // Request sampled at the next edge; response read one negedge later.
  task automatic issue(input logic side, input logic cfg, input logic [7:0] bus,
                       input logic [31:0] a);
    req_valid = 1'b1; req_side = side; req_cfg = cfg; req_bus = bus; req_addr = a;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  initial begin
    #2_000_000;
    errors++; checks++;
    $display("FAIL watchdog: got timeout, exp completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    checks++; // R10 reset state
    if (rsp_valid || rsp_hit || rsp_miss || rsp_cfg_ok || rsp_addr != 0) begin
      errors++;
      $display("FAIL R10: got v=%0b h=%0b m=%0b addr=%h, exp all zero",
               rsp_valid, rsp_hit, rsp_miss, rsp_addr);
    end
    issue(1'b0, 1'b0, 8'd0, 32'h0000_0000);
    check("R10 no window after reset", K_MISS, 2'd0, 32'h0);

    wr_win(1'b0, 0, 32'h1000_0000, setup_w(1, 0, 16, 0), 32'h8000_0000);
    wr_win(1'b0, 1, 32'h1000_0000, setup_w(1, 0, 20, 0), 32'h4000_0000);
    wr_win(1'b0, 2, 32'h2000_0000, setup_w(1, 1, 24, 16), 32'h0);
    wr_win(1'b0, 3, 32'h3000_0000, setup_w(0, 0, 12, 0), 32'h0);
    wr_win(1'b1, 0, 32'h1000_0000, setup_w(1, 0, 12, 0), 32'h0005_0000);
    wr_win(1'b1, 1, 32'h4000_0000, setup_w(1, 1, 28, 20), 32'h0);
    wr({2'b01, 1'b0, 5'd3}, 32'hABCD_0001);
    wr({2'b01, 1'b1, 5'd3}, 32'h1230_0001);
    wr(8'h80, 32'h0000_0005);

    for (int i = 0; i < NV; i++) begin
      req_valid = 1'b1; req_side = VEC[i].side; req_cfg = VEC[i].cfg;
      req_bus = VEC[i].bus; req_addr = VEC[i].addr;
      @(negedge clk);
      check($sformatf("R%0d vector %0d", VEC[i].req, i), VEC[i].kind, VEC[i].win,
            VEC[i].xaddr);
    end
    req_valid = 1'b0;
    @(negedge clk);
    checks++; // R1 idle cycle after a stream
    if (rsp_valid || rsp_hit || rsp_miss || rsp_cfg_ok) begin
      errors++;
      $display("FAIL R1: got v=%0b h=%0b m=%0b c=%0b, exp all low",
               rsp_valid, rsp_hit, rsp_miss, rsp_cfg_ok);
    end

    // R9: enable an entry, then use it on the next request
    wr({2'b01, 1'b0, 5'd4}, 32'h5550_0001);
    issue(1'b0, 1'b0, 8'd0, 32'h2004_0000);
    check("R9 new table entry", K_HIT, 2'd2, 32'h5550_0000);

    // R4: move the index field of window 2 up to bit 20
    wr({2'b00, 1'b0, 2'd1, 3'd2}, setup_w(1, 1, 24, 20));
    issue(1'b0, 1'b0, 8'd0, 32'h2033_0000);
    check("R4 moved index position", K_HIT, 2'd2, 32'hABC3_0000);

    // R7: disable window 0, the overlapping window 1 takes over
    wr({2'b00, 1'b0, 2'd1, 3'd0}, setup_w(0, 0, 16, 0));
    issue(1'b0, 1'b0, 8'd0, 32'h1000_1234);
    check("R7 fallback to window 1", K_HIT, 2'd1, 32'h4000_1234);

    // R2: size below the minimum acts as 4 KiB
    wr({2'b00, 1'b0, 2'd1, 3'd3}, setup_w(1, 0, 3, 0));
    issue(1'b0, 1'b0, 8'd0, 32'h3000_0FFC);
    check("R2 minimum size", K_HIT, 2'd3, 32'h0000_0FFC);

    // R8: change own bus number
    wr(8'h80, 32'h0000_0006);
    issue(1'b0, 1'b1, 8'd6, 32'h0);
    check("R8 new bus number", K_CFG, 2'd0, 32'h0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule